// File: doc/BRIEF.md
# Systolic Mesh Matrix Multiplier

The block multiplies two square N×N matrices of unsigned W-bit elements, C = A·B, on a square grid of multiply-accumulate cells. Each cell owns one element of C. The A operands enter along the top edge and move down one cell per cycle. The B operands enter along the left edge and move right one cell per cycle. A built-in feeder staggers the injection, so each matching pair of operands meets in the cell that owns their output element. Every operand carries a valid bit, and a cell accumulates only when both of its incoming operands are valid.

The operands are written one element at a time into two register banks through a valid/ready load port. The port exerts back-pressure only while a computation runs: ld_ready is low from the edge that accepts start until done rises. A producer that is stalled holds ld_valid and its payload until the handshake completes. The result array has no back-pressure. It holds its value and done stays high until the next accepted start, which clears every accumulator.

A run takes 3N−2 cycles. In zero-based indices, element A[i][k] enters the top of grid column i at step i+k and element B[k][j] enters the left of grid row j at step j+k. The two meet in the cell at row j, column i at step i+j+k. The last pair reaches the far corner at step 3N−3.

Top module: `mm_systolic_mesh`

## Requirements
- R1: A load is taken on a rising edge where ld_valid and ld_ready are both high. It writes ld_data into matrix A when ld_sel_b is 0, or into matrix B when ld_sel_b is 1, at row ld_row and column ld_col. ld_ready is high when idle and low while computing, and a load offered while ld_ready is low changes no operand.
- R2: A start sampled while idle begins a run and clears all accumulators. A start sampled during a run is ignored and does not change the run's timing or result.
- R3: After a run, result holds C[i][j] = sum over k of A[i][k]·B[k][j], unsigned, at bits [(i·N+j)·ACCW +: ACCW].
- R4: done rises on the (3N−2)-th rising edge after the edge that accepts start. It stays high until the edge that accepts the next start, where it falls.
- R5: ACCW = 2W + ceil(log2 N), and a run with every operand at its maximum value produces the exact sum N·(2^W−1)^2 with no wrap.
- R6: While idle, result does not change, even when new operands are loaded. done also stays high.
- R7: The operand banks keep their contents across runs, so a second start without reloading gives the same result.
- R8: After reset, done is 0, ld_ready is 1, result is all zeros and both operand banks are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ld_valid | input | 1 | Operand load offered |
| ld_ready | output | 1 | Operand load can be taken (idle) |
| ld_sel_b | input | 1 | 0 writes matrix A, 1 writes matrix B |
| ld_row | input | max(1,clog2 N) | Row index of the element |
| ld_col | input | max(1,clog2 N) | Column index of the element |
| ld_data | input | W | Element value, unsigned |
| start | input | 1 | Pulse that begins a run when idle |
| done | output | 1 | Result valid; held until next accepted start |
| result | output | N·N·ACCW | Product matrix, element (i,j) at offset (i·N+j)·ACCW |

## Verification
The hardest situation to create from the ports is a busy mesh that receives interfering traffic. This means a second start and a load offered in the middle of a run, while the skewed operand wavefront is only partly through the grid. The stimulus raises both while the run is several steps in. It then confirms that done still arrives exactly 3N−2 edges after the original start and that the product matches the untouched operands. Finally, it restarts without reloading to show that the blocked load never reached the banks. A run with all operands at full scale drives every accumulator to its largest possible sum.

// File: rtl/mm_pkg.sv
package mm_pkg;

  // Accumulator width: full product plus growth for N summed terms.
  function automatic int unsigned mm_acc_width(input int unsigned w, input int unsigned n);
    return 2 * w + ((n > 1) ? $clog2(n) : 0);
  endfunction

endpackage

// File: rtl/mm_operand_bank.sv
module mm_operand_bank #(
  parameter int N  = 4,
  parameter int W  = 8,
  parameter int IW = 2
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_sel_b,
  input  logic [IW-1:0]    wr_row,
  input  logic [IW-1:0]    wr_col,
  input  logic [W-1:0]     wr_data,
  output logic [N*N*W-1:0] a_flat,
  output logic [N*N*W-1:0] b_flat
);

  for (genvar r = 0; r < N; r++) begin : g_row
    for (genvar c = 0; c < N; c++) begin : g_col
      logic [W-1:0] a_q, b_q;
      logic         hit;

      assign hit = wr_en && (wr_row == IW'(r)) && (wr_col == IW'(c));

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          a_q <= '0;
          b_q <= '0;
        end else if (hit) begin
          if (wr_sel_b) b_q <= wr_data;
          else          a_q <= wr_data;
        end
      end

      assign a_flat[(r*N+c)*W +: W] = a_q;
      assign b_flat[(r*N+c)*W +: W] = b_q;
    end
  end

endmodule

// File: rtl/mm_skew_feeder.sv
module mm_skew_feeder #(
  parameter int N  = 4,
  parameter int W  = 8,
  parameter int SW = 4
)(
  input  logic             run,
  input  logic [SW-1:0]    step,
  input  logic [N*N*W-1:0] a_flat,
  input  logic [N*N*W-1:0] b_flat,
  output logic [N*W-1:0]   top_a,
  output logic [N-1:0]     top_v,
  output logic [N*W-1:0]   left_b,
  output logic [N-1:0]     left_v
);

  // Lane g injects A[g][k] into grid column g and B[k][g] into grid row g,
  // with k = step - g, for steps g .. g+N-1.
  for (genvar g = 0; g < N; g++) begin : g_lane
    logic [SW-1:0] k, ksel;
    logic          live;

    assign k    = step - SW'(g);
    assign live = run && (step >= SW'(g)) && (k < SW'(N));
    assign ksel = live ? k : '0;

    assign top_v[g]            = live;
    assign left_v[g]           = live;
    assign top_a[g*W +: W]     = a_flat[(g*N + int'(ksel))*W +: W];
    assign left_b[g*W +: W]    = b_flat[(int'(ksel)*N + g)*W +: W];
  end

endmodule

// File: rtl/mm_mac_cell.sv
module mm_mac_cell #(
  parameter int W    = 8,
  parameter int ACCW = 18
)(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic [W-1:0]    a,
  input  logic            a_v,
  input  logic [W-1:0]    b,
  input  logic            b_v,
  output logic [ACCW-1:0] acc
);

  logic [2*W-1:0] prod;

  assign prod = {{W{1'b0}}, a} * {{W{1'b0}}, b};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          acc <= '0;
    else if (clr)        acc <= '0;
    else if (a_v && b_v) acc <= acc + ACCW'(prod);
  end

endmodule

// File: rtl/mm_systolic_mesh.sv
module mm_systolic_mesh
  import mm_pkg::*;
#(
  parameter  int N    = 4,
  parameter  int W    = 8,
  localparam int IW   = (N > 1) ? $clog2(N) : 1,
  localparam int ACCW = mm_acc_width(W, N)
)(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ld_valid,
  output logic                ld_ready,
  input  logic                ld_sel_b,
  input  logic [IW-1:0]       ld_row,
  input  logic [IW-1:0]       ld_col,
  input  logic [W-1:0]        ld_data,
  input  logic                start,
  output logic                done,
  output logic [N*N*ACCW-1:0] result
);

  localparam int SW   = $clog2(3 * N);
  localparam int LAST = 3 * N - 3;

  logic          busy_q, done_q, go;
  logic [SW-1:0] step_q;

  assign go       = start && !busy_q;
  assign ld_ready = !busy_q;
  assign done     = done_q;

  // Run sequencer: steps 0 .. 3N-3, done one cycle after the final step.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      step_q <= '0;
    end else if (go) begin
      busy_q <= 1'b1;
      done_q <= 1'b0;
      step_q <= '0;
    end else if (busy_q) begin
      if (step_q == SW'(LAST)) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
      end else begin
        step_q <= step_q + 1'b1;
      end
    end
  end

  logic [N*N*W-1:0] a_flat, b_flat;

  mm_operand_bank #(.N(N), .W(W), .IW(IW)) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (ld_valid && ld_ready),
    .wr_sel_b (ld_sel_b),
    .wr_row   (ld_row),
    .wr_col   (ld_col),
    .wr_data  (ld_data),
    .a_flat   (a_flat),
    .b_flat   (b_flat)
  );

  logic [N*W-1:0] top_a, left_b;
  logic [N-1:0]   top_v, left_v;

  mm_skew_feeder #(.N(N), .W(W), .SW(SW)) u_feed (
    .run    (busy_q),
    .step   (step_q),
    .a_flat (a_flat),
    .b_flat (b_flat),
    .top_a  (top_a),
    .top_v  (top_v),
    .left_b (left_b),
    .left_v (left_v)
  );

  // Forwarded operands leaving each cell (down for A, right for B).
  logic [W-1:0] a_fw  [N][N];
  logic         av_fw [N][N];
  logic [W-1:0] b_fw  [N][N];
  logic         bv_fw [N][N];

  for (genvar r = 0; r < N; r++) begin : g_row
    for (genvar c = 0; c < N; c++) begin : g_col
      logic [W-1:0]    a_here, b_here;
      logic            av_here, bv_here;
      logic [ACCW-1:0] acc;

      if (r == 0) begin : g_a_edge
        assign a_here  = top_a[c*W +: W];
        assign av_here = top_v[c];
      end else begin : g_a_link
        assign a_here  = a_fw[r-1][c];
        assign av_here = av_fw[r-1][c];
      end

      if (c == 0) begin : g_b_edge
        assign b_here  = left_b[r*W +: W];
        assign bv_here = left_v[r];
      end else begin : g_b_link
        assign b_here  = b_fw[r][c-1];
        assign bv_here = bv_fw[r][c-1];
      end

      if (r < N - 1) begin : g_a_fwd
        logic [W-1:0] a_q;
        logic         av_q;
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) begin
            a_q  <= '0;
            av_q <= 1'b0;
          end else begin
            a_q  <= a_here;
            av_q <= av_here;
          end
        end
        assign a_fw[r][c]  = a_q;
        assign av_fw[r][c] = av_q;
      end else begin : g_a_drop
        assign a_fw[r][c]  = '0;
        assign av_fw[r][c] = 1'b0;
      end

      if (c < N - 1) begin : g_b_fwd
        logic [W-1:0] b_q;
        logic         bv_q;
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) begin
            b_q  <= '0;
            bv_q <= 1'b0;
          end else begin
            b_q  <= b_here;
            bv_q <= bv_here;
          end
        end
        assign b_fw[r][c]  = b_q;
        assign bv_fw[r][c] = bv_q;
      end else begin : g_b_drop
        assign b_fw[r][c]  = '0;
        assign bv_fw[r][c] = 1'b0;
      end

      mm_mac_cell #(.W(W), .ACCW(ACCW)) u_mac (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (go),
        .a     (a_here),
        .a_v   (av_here),
        .b     (b_here),
        .b_v   (bv_here),
        .acc   (acc)
      );

      // Cell at grid row r, column c owns C[c][r].
      assign result[(c*N + r)*ACCW +: ACCW] = acc;
    end
  end

endmodule

// File: rtl/mm_mesh_chk.sv
module mm_mesh_chk
  import mm_pkg::*;
#(
  parameter int N = 4,
  parameter int W = 8
)(
  input logic                                   clk,
  input logic                                   rst_n,
  input logic                                   start,
  input logic                                   ld_ready,
  input logic                                   busy,
  input logic [$clog2(3*N)-1:0]                 step,
  input logic                                   done,
  input logic [N*N*mm_acc_width(W, N)-1:0]      result
);

  localparam int SW   = $clog2(3 * N);
  localparam int LAST = 3 * N - 3;

  // R1: an accepted start closes the load port on the next cycle
  p_port_closes_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (start && ld_ready) |=> !ld_ready);

  // R2: start while idle opens a run at step zero with done cleared
  p_start_opens_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (busy && step == '0 && !done));

  // R2: a run advances one step per cycle regardless of start
  p_run_advances_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && step != SW'(LAST)) |=> (busy && step == SW'($past(step) + 1'b1)));

  // R4: done only rises right after the final step
  p_done_timing_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> ($past(busy) && $past(step) == SW'(LAST)));

  // R4: done holds until a start arrives
  p_done_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done);

  // R6: results frozen while idle and no start
  p_idle_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(result));

endmodule

bind mm_systolic_mesh mm_mesh_chk #(.N(N), .W(W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .ld_ready (ld_ready),
  .busy     (busy_q),
  .step     (step_q),
  .done     (done),
  .result   (result)
);

// File: tb/sim_mm_systolic_mesh.sv
module sim_mm_systolic_mesh;
  import mm_pkg::*;

  localparam int N    = 4;
  localparam int W    = 8;
  localparam int IW   = (N > 1) ? $clog2(N) : 1;
  localparam int ACCW = mm_acc_width(W, N);
  localparam int RW   = N * N * ACCW;
  localparam int LAT  = 3 * N - 2;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          ld_valid, ld_ready, ld_sel_b, start, done;
  logic [IW-1:0] ld_row, ld_col;
  logic [W-1:0]  ld_data;
  logic [RW-1:0] result;

  always #10 clk = ~clk;

  mm_systolic_mesh #(.N(N), .W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_ready(ld_ready),
    .ld_sel_b(ld_sel_b), .ld_row(ld_row), .ld_col(ld_col), .ld_data(ld_data),
    .start(start), .done(done), .result(result)
  );

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  int start_cyc = 0;
  bit finished = 1'b0;

  logic [W-1:0]  ma [N][N];
  logic [W-1:0]  mb [N][N];
  logic [RW-1:0] last_exp;
  logic [RW-1:0] expq [$];
  string         tagq [$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [RW-1:0] model();
    logic [RW-1:0] v = '0;
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++) begin
        longint s = 0;
        for (int k = 0; k < N; k++) s += longint'(ma[i][k]) * longint'(mb[k][j]);
        v[(i*N+j)*ACCW +: ACCW] = ACCW'(s);
      end
    return v;
  endfunction

  task automatic ld(input bit sel, input int r, input int c, input logic [W-1:0] d);
    @(negedge clk);
    ld_valid = 1'b1; ld_sel_b = sel;
    ld_row = IW'(r); ld_col = IW'(c); ld_data = d;
    @(posedge clk);
  endtask

  task automatic load_all();
    for (int r = 0; r < N; r++)
      for (int c = 0; c < N; c++) begin
        ld(1'b0, r, c, ma[r][c]);
        ld(1'b1, r, c, mb[r][c]);
      end
    @(negedge clk);
    ld_valid = 1'b0;
  endtask

  // Driver: launch a run and push its expected product to the scoreboard.
  task automatic fire(input string tag);
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    start_cyc = cyc;
    chk(done == 1'b0, "R4 done clears on start", longint'(done), 0);
    chk(ld_ready == 1'b0, "R1 ready low while busy", longint'(ld_ready), 0);
    last_exp = model();
    expq.push_back(last_exp);
    tagq.push_back(tag);
  endtask

  task automatic wait_idle();
    while (expq.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  // Monitor: on each rising done, pop and compare latency and every element.
  initial begin
    logic seen;
    seen = 1'b0;
    forever begin
      @(negedge clk);
      if (done && !seen) begin
        if (expq.size() == 0) begin
          chk(1'b0, "R2 unexpected done", 1, 0);
        end else begin
          logic [RW-1:0] e;
          string t;
          e = expq.pop_front();
          t = tagq.pop_front();
          chk((cyc - start_cyc) == LAT, "R4 latency", longint'(cyc - start_cyc), LAT);
          for (int i = 0; i < N; i++)
            for (int j = 0; j < N; j++)
              chk(result[(i*N+j)*ACCW +: ACCW] == e[(i*N+j)*ACCW +: ACCW], t,
                  longint'(result[(i*N+j)*ACCW +: ACCW]), longint'(e[(i*N+j)*ACCW +: ACCW]));
        end
      end
      seen = done;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog R4 actual=%0d expected=%0d", cyc, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; ld_valid = 1'b0; ld_sel_b = 1'b0; start = 1'b0;
    ld_row = '0; ld_col = '0; ld_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R8: reset state at the ports
    chk(done == 1'b0, "R8 done after reset", longint'(done), 0);
    chk(ld_ready == 1'b1, "R8 ready after reset", longint'(ld_ready), 1);
    chk(result == '0, "R8 result zero", (result == '0) ? 0 : 1, 0);

    // R3: identity times a counting matrix
    for (int r = 0; r < N; r++)
      for (int c = 0; c < N; c++) begin
        ma[r][c] = (r == c) ? W'(1) : W'(0);
        mb[r][c] = W'(r*N + c + 1);
      end
    load_all();
    fire("R3 identity");
    wait_idle();

    // R3: random operands
    for (int r = 0; r < N; r++)
      for (int c = 0; c < N; c++) begin
        ma[r][c] = W'($urandom_range(0, 255));
        mb[r][c] = W'($urandom_range(0, 255));
      end
    load_all();
    fire("R3 random");
    wait_idle();

    // R7: restart without reloading
    fire("R7 banks retained");
    wait_idle();

    // R5: every operand at full scale
    for (int r = 0; r < N; r++)
      for (int c = 0; c < N; c++) begin
        ma[r][c] = '1;
        mb[r][c] = '1;
      end
    load_all();
    fire("R5 full scale");
    wait_idle();

    // R2 and R1: second start and a load offered mid-run
    for (int r = 0; r < N; r++)
      for (int c = 0; c < N; c++) begin
        ma[r][c] = W'($urandom_range(0, 255));
        mb[r][c] = W'(r + 2*c + 1);
      end
    load_all();
    fire("R2 start ignored while busy");
    repeat (3) @(negedge clk);
    start = 1'b1;
    ld_valid = 1'b1; ld_sel_b = 1'b0; ld_row = '0; ld_col = '0; ld_data = ~ma[0][0];
    chk(ld_ready == 1'b0, "R1 load refused mid-run", longint'(ld_ready), 0);
    @(negedge clk);
    start = 1'b0;
    ld_valid = 1'b0;
    wait_idle();
    fire("R1 busy load had no effect");
    wait_idle();

    // R6: idle load leaves result and done untouched
    ld(1'b0, 0, 0, ma[0][0] + W'(7));
    @(negedge clk);
    ld_valid = 1'b0;
    chk(result == last_exp, "R6 result held after idle load", (result == last_exp) ? 0 : 1, 0);
    chk(done == 1'b1, "R6 done held after idle load", longint'(done), 1);
    ma[0][0] = ma[0][0] + W'(7);
    fire("R1 idle load used by next run");
    wait_idle();

    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule